// File: doc/BRIEF.md
# PLL Control and Lock-Status Registers

This block is the register front end of a single PLL. A one-cycle write port and a combinational read port reach four word registers: a control word, a status word, a frequency word and a general-purpose monitor word. The control word holds power-down, bypass, three divider codes and a band field. The block decodes the divider codes into their real divide and multiply factors and drives them out for any rate calculator or checker nearby. It also computes the resulting output rate from a reference-rate parameter.

No analog PLL is attached. A lock emulator stands in for it. Every control write drops the lock flag and restarts a settle counter, and lock returns after a programmed number of cycles. Each control write is also checked against legal ranges for the input divide and the feedback multiply. A configuration error flag records the result of the most recent control write.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control word reads CTRL_RST (default 0x1, powered down), the status word reads 0, the monitor word reads 0 and the frequency word reads 0.
- R2: A write to word 0 (address bits [3:2] = 0) stores bits 15:0 and the band field at bits 23:20; bits 19:16 and 31:24 read back as zero. Address bits [1:0] do not take part in decoding.
- R3: The input divide output equals the code in control bits 8:4 plus one.
- R4: The feedback multiply output equals two times (the code in control bits 15:9 plus one).
- R5: The output divide output equals 2 raised to the code in control bits 3:2.
- R6: With bypass (control bit 1) set, the rate equals REF_RATE. With power-down (bit 0) set and bypass clear, the rate is 0. Otherwise the rate is floor(REF_RATE × multiply ÷ (input divide × output divide)). The frequency word (word 2) reads this rate, saturated to 0xFFFFFFFF.
- R7: A control write clears the lock flag (status bit 0) at its own clock edge. Lock reads 1 again exactly SETTLE_CYCLES edges after that edge, and stays 1 until the next control write.
- R8: A control write whose input divide lies outside [ID_MIN, ID_MAX], or whose multiply lies outside [FB_MIN, FB_MAX], sets the error flag (status bit 1). The next legal control write clears it. Defaults: 1..16 and 4..200.
- R9: Writes to the status word (word 1) and the frequency word (word 2) change no register: the control word, lock and error are unaffected.
- R10: The monitor word (word 3) stores all 32 written bits and reads them back. Writing it leaves the control word, lock and error unaffected.
- R11: A control write made while settling restarts the count, so lock returns SETTLE_CYCLES edges after the latest control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word, combinational |
| idiv_o | output | 6 | Decoded input divide (1..32) |
| fbmul_o | output | 9 | Decoded feedback multiply (2..256) |
| odiv_o | output | 4 | Decoded output divide (1, 2, 4, 8) |
| lock_o | output | 1 | Emulated lock flag |
| err_o | output | 1 | Configuration error flag |
| rate_o | output | RATE_W | Computed output rate |

## Verification
The stored control word, the three decoded factors, the rate and the error flag all change at the write's clock edge. The bench therefore samples them on the falling edge right after the write. Read data is combinational and is sampled one time step after the address is set. Lock falls at the write edge and rises SETTLE_CYCLES edges later. The bench counts falling edges after the write and checks that lock is low one edge before that point and high at it. The sweep covers every divider code combination with arithmetic expected values.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

   localparam int unsigned DATA_W        = 32;

   // control word layout (bit positions are decoded by neighbours)
   localparam int unsigned PD_BIT        = 0;
   localparam int unsigned BYP_BIT       = 1;
   localparam int unsigned OD_LSB        = 2;
   localparam int unsigned OD_W          = 2;
   localparam int unsigned ID_LSB        = 4;
   localparam int unsigned ID_W          = 5;
   localparam int unsigned FB_LSB        = 9;
   localparam int unsigned FB_W          = 7;
   localparam int unsigned BAND_LSB      = 20;

   // status word layout
   localparam int unsigned STAT_LOCK_BIT = 0;
   localparam int unsigned STAT_ERR_BIT  = 1;

   // word select, taken from byte address bits [3:2]
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_FREQ = 2'd2,
      SEL_MON  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [FB_W-1:0] fb_code;
      logic [ID_W-1:0] id_code;
      logic [OD_W-1:0] od_code;
      logic            bypass;
      logic            pwr_dn;
   } ctl_fields_t;

   function automatic ctl_fields_t unpack_ctl(input logic [DATA_W-1:0] w);
      ctl_fields_t f;
      f.pwr_dn  = w[PD_BIT];
      f.bypass  = w[BYP_BIT];
      f.od_code = w[OD_LSB +: OD_W];
      f.id_code = w[ID_LSB +: ID_W];
      f.fb_code = w[FB_LSB +: FB_W];
      return f;
   endfunction

endpackage

// File: rtl/pll_ctl_decode.sv
module pll_ctl_decode
   import pll_ctl_pkg::*;
#(
   parameter int unsigned ID_MIN      = 1,
   parameter int unsigned ID_MAX      = 16,
   parameter int unsigned FB_MIN      = 4,
   parameter int unsigned FB_MAX      = 200,
   parameter bit          RANGE_CHECK = 1'b1
) (
   input  ctl_fields_t           fields_i,
   output logic [ID_W:0]         idiv_o,
   output logic [FB_W+1:0]       fbmul_o,
   output logic [(2**OD_W)-1:0]  odiv_o,
   output logic                  illegal_o
);

   localparam int unsigned OD_OW = 2**OD_W;

   if (ID_MIN > ID_MAX) begin : g_bad_id_range
      $error("pll_ctl_decode: ID_MIN above ID_MAX");
   end
   if (FB_MIN > FB_MAX) begin : g_bad_fb_range
      $error("pll_ctl_decode: FB_MIN above FB_MAX");
   end

   // input divide: code + 1
   assign idiv_o  = {1'b0, fields_i.id_code} + (ID_W+1)'(1);
   // feedback multiply: 2 * (code + 1)
   assign fbmul_o = {({1'b0, fields_i.fb_code} + (FB_W+1)'(1)), 1'b0};
   // output divide: 2 ** code
   assign odiv_o  = OD_OW'(1) << fields_i.od_code;

   if (RANGE_CHECK) begin : g_range
      logic id_bad;
      logic fb_bad;
      assign id_bad    = (32'(idiv_o) < ID_MIN) || (32'(idiv_o) > ID_MAX);
      assign fb_bad    = (32'(fbmul_o) < FB_MIN) || (32'(fbmul_o) > FB_MAX);
      assign illegal_o = id_bad | fb_bad;
   end else begin : g_no_range
      assign illegal_o = 1'b0;
   end

endmodule

// File: rtl/pll_lock_emu.sv
module pll_lock_emu #(
   parameter int unsigned SETTLE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic bad_cfg_i,
   output logic lock_o,
   output logic err_o
);

   localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("pll_lock_emu: SETTLE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             lock_q;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
         err_q  <= 1'b0;
      end else if (restart_i) begin
         cnt_q  <= '0;
         lock_q <= 1'b0;
         err_q  <= bad_cfg_i;
      end else if (!lock_q) begin
         if (cnt_q == CNT_LAST) begin
            lock_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign lock_o = lock_q;
   assign err_o  = err_q;

   AST_RESTART_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> !lock_q); // R7
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !restart_i) |=> lock_q); // R7
   AST_LOCK_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> !$past(restart_i)); // R11

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
   import pll_ctl_pkg::*;
#(
   parameter int unsigned REF_RATE = 33333333,
   parameter int unsigned RATE_W   = 34
) (
   input  logic              pwr_dn_i,
   input  logic              bypass_i,
   input  logic [ID_W:0]     idiv_i,
   input  logic [FB_W+1:0]   fbmul_i,
   input  logic [OD_W-1:0]   od_code_i,
   output logic [RATE_W-1:0] rate_o
);

   localparam int unsigned REF_W = $clog2(REF_RATE + 1);
   localparam int unsigned NUM_W = REF_W + FB_W + 2;

   if (RATE_W < NUM_W) begin : g_bad_rate_w
      $error("pll_rate_calc: RATE_W too narrow for REF_RATE times maximum multiply");
   end

   logic [NUM_W-1:0] num;
   logic [NUM_W-1:0] quo;
   logic [NUM_W-1:0] shifted;
   logic [NUM_W-1:0] sel_rate;

   always_comb begin
      num     = NUM_W'(REF_RATE) * NUM_W'(fbmul_i);
      // idiv_i is never zero: the decoder adds one to the code
      quo     = num / NUM_W'(idiv_i);
      // output divide is a power of two: floor division nests exactly
      shifted = quo >> od_code_i;
      if (bypass_i) begin
         sel_rate = NUM_W'(REF_RATE);
      end else if (pwr_dn_i) begin
         sel_rate = '0;
      end else begin
         sel_rate = shifted;
      end
   end

   assign rate_o = RATE_W'(sel_rate);

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
   import pll_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned BAND_W        = 4,
   parameter int unsigned SETTLE_CYCLES = 8,
   parameter int unsigned REF_RATE      = 33333333,
   parameter int unsigned RATE_W        = 34,
   parameter int unsigned ID_MIN        = 1,
   parameter int unsigned ID_MAX        = 16,
   parameter int unsigned FB_MIN        = 4,
   parameter int unsigned FB_MAX        = 200,
   parameter bit          RANGE_CHECK   = 1'b1,
   parameter bit          MON_EN        = 1'b1,
   parameter logic [31:0] CTRL_RST      = 32'h0000_0001
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic [ID_W:0]        idiv_o,
   output logic [FB_W+1:0]      fbmul_o,
   output logic [(2**OD_W)-1:0] odiv_o,
   output logic                 lock_o,
   output logic                 err_o,
   output logic [RATE_W-1:0]    rate_o
);

   localparam logic [DATA_W-1:0] LOW_MASK  = DATA_W'((64'd1 << (FB_LSB + FB_W)) - 64'd1);
   localparam logic [DATA_W-1:0] BAND_MASK = DATA_W'(((64'd1 << BAND_W) - 64'd1) << BAND_LSB);
   localparam logic [DATA_W-1:0] CTRL_MASK = LOW_MASK | BAND_MASK;

   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("pll_ctl_regs: ADDR_W must be at least 4");
   end
   if (BAND_LSB + BAND_W > DATA_W) begin : g_bad_band_w
      $error("pll_ctl_regs: band field runs past bit 31");
   end
   if (BAND_LSB < FB_LSB + FB_W) begin : g_band_overlap
      $error("pll_ctl_regs: band field overlaps feedback code");
   end

   // ------------------------------------------------------------ decode
   reg_sel_e sel;
   logic     wr_ctrl;
   logic     wr_mon;

   assign sel     = reg_sel_e'(addr[3:2]);
   assign wr_ctrl = wr_en && (sel == SEL_CTRL);
   assign wr_mon  = wr_en && (sel == SEL_MON);

   logic [ADDR_W-1:0] unused_addr;
   assign unused_addr = addr;

   // ------------------------------------------------------------ control word
   logic [DATA_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST & CTRL_MASK;
      end else if (wr_ctrl) begin
         ctrl_q <= wdata & CTRL_MASK;
      end
   end

   ctl_fields_t cur_f;
   ctl_fields_t wr_f;

   assign cur_f = unpack_ctl(ctrl_q);
   assign wr_f  = unpack_ctl(wdata);

   // decode of the live control word drives the outputs
   logic cur_illegal;

   pll_ctl_decode #(
      .ID_MIN      (ID_MIN),
      .ID_MAX      (ID_MAX),
      .FB_MIN      (FB_MIN),
      .FB_MAX      (FB_MAX),
      .RANGE_CHECK (RANGE_CHECK)
   ) i_dec_cur (
      .fields_i  (cur_f),
      .idiv_o    (idiv_o),
      .fbmul_o   (fbmul_o),
      .odiv_o    (odiv_o),
      .illegal_o (cur_illegal)
   );

   logic unused_cur_illegal;
   assign unused_cur_illegal = cur_illegal;

   // decode of the incoming word judges legality at write time
   logic [ID_W:0]        wr_idiv;
   logic [FB_W+1:0]      wr_fbmul;
   logic [(2**OD_W)-1:0] wr_odiv;
   logic                 wr_illegal;

   pll_ctl_decode #(
      .ID_MIN      (ID_MIN),
      .ID_MAX      (ID_MAX),
      .FB_MIN      (FB_MIN),
      .FB_MAX      (FB_MAX),
      .RANGE_CHECK (RANGE_CHECK)
   ) i_dec_wr (
      .fields_i  (wr_f),
      .idiv_o    (wr_idiv),
      .fbmul_o   (wr_fbmul),
      .odiv_o    (wr_odiv),
      .illegal_o (wr_illegal)
   );

   logic unused_wr_dec;
   assign unused_wr_dec = ^{wr_idiv, wr_fbmul, wr_odiv};

   // ------------------------------------------------------------ lock and error
   pll_lock_emu #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) i_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (wr_ctrl),
      .bad_cfg_i (wr_illegal),
      .lock_o    (lock_o),
      .err_o     (err_o)
   );

   // ------------------------------------------------------------ rate
   pll_rate_calc #(
      .REF_RATE (REF_RATE),
      .RATE_W   (RATE_W)
   ) i_rate (
      .pwr_dn_i  (cur_f.pwr_dn),
      .bypass_i  (cur_f.bypass),
      .idiv_i    (idiv_o),
      .fbmul_i   (fbmul_o),
      .od_code_i (cur_f.od_code),
      .rate_o    (rate_o)
   );

   logic [DATA_W-1:0] freq_rd;

   if (RATE_W > DATA_W) begin : g_freq_sat
      assign freq_rd = (|rate_o[RATE_W-1:DATA_W]) ? '1 : rate_o[DATA_W-1:0];
   end else begin : g_freq_ext
      assign freq_rd = DATA_W'(rate_o);
   end

   // ------------------------------------------------------------ monitor word
   logic [DATA_W-1:0] mon_rd;

   if (MON_EN) begin : g_mon
      logic [DATA_W-1:0] mon_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mon_q <= '0;
         end else if (wr_mon) begin
            mon_q <= wdata;
         end
      end
      assign mon_rd = mon_q;
   end else begin : g_no_mon
      assign mon_rd = '0;
   end

   // ------------------------------------------------------------ read mux
   logic [DATA_W-1:0] stat_rd;

   always_comb begin
      stat_rd                = '0;
      stat_rd[STAT_LOCK_BIT] = lock_o;
      stat_rd[STAT_ERR_BIT]  = err_o;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: rdata = ctrl_q;
         SEL_STAT: rdata = stat_rd;
         SEL_FREQ: rdata = freq_rd;
         SEL_MON:  rdata = mon_rd;
         default:  rdata = '0;
      endcase
   end

   // ------------------------------------------------------------ assertions
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q)); // R9
   AST_ERR_ON_BAD_IDIV: assert property (@(posedge clk) disable iff (!rst_n)
      (RANGE_CHECK && wr_en && (addr[3:2] == 2'd0) &&
       ((32'(wdata[ID_LSB +: ID_W]) + 32'd1) > ID_MAX)) |=> err_o); // R8

endmodule

// File: tb/test_pll_ctl_regs.sv
module test_pll_ctl_regs;

   localparam int    CLK_PERIOD = 10;
   localparam longint REF       = 33333333;
   localparam int    SETTLE     = 8;
   localparam int    IMIN = 1, IMAX = 16, FMIN = 4, FMAX = 200;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [3:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic [5:0]  idiv_o;
   logic [8:0]  fbmul_o;
   logic [3:0]  odiv_o;
   logic        lock_o;
   logic        err_o;
   logic [33:0] rate_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_ctl_regs i_pll_ctl_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .idiv_o  (idiv_o),
      .fbmul_o (fbmul_o),
      .odiv_o  (odiv_o),
      .lock_o  (lock_o),
      .err_o   (err_o),
      .rate_o  (rate_o)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // write one word: drive at a falling edge, return one falling edge later
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic longint exp_rate(int fc, int ic, int oc, bit pd, bit byp);
      if (byp) return REF;
      if (pd)  return 0;
      return ((REF * 2 * (fc + 1)) / (ic + 1)) >>> oc;
   endfunction

   function automatic longint sat32(longint r);
      return (r > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : r;
   endfunction

   function automatic bit exp_err(int fc, int ic);
      int idv = ic + 1;
      int fbm = 2 * (fc + 1);
      return (idv < IMIN) || (idv > IMAX) || (fbm < FMIN) || (fbm > FMAX);
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] ctl_keep;
      rst_n = 1'b0;
      wr_en = 1'b0;
      addr  = '0;
      wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, d); check("R1 ctrl reset", d, 1);
      rd(4'h4, d); check("R1 status reset", d, 0);
      rd(4'hC, d); check("R1 monitor reset", d, 0);
      rd(4'h8, d); check("R1 freq reset", d, 0);

      // R7 lock after reset release
      repeat (SETTLE - 1) @(negedge clk);
      check("R7 lock low before settle", lock_o, 0);
      @(negedge clk);
      check("R7 lock high at settle", lock_o, 1);

      // R3 R4 R5 R6 R8 exhaustive divider sweep
      for (int fc = 0; fc < 128; fc++) begin
         for (int ic = 0; ic < 32; ic++) begin
            for (int oc = 0; oc < 4; oc++) begin
               wr(4'h0, (32'(fc) << 9) | (32'(ic) << 4) | (32'(oc) << 2));
               check("R3 input divide", idiv_o, ic + 1);
               check("R4 feedback multiply", fbmul_o, 2 * (fc + 1));
               check("R5 output divide", odiv_o, 1 << oc);
               check("R6 rate", rate_o, exp_rate(fc, ic, oc, 1'b0, 1'b0));
               check("R8 error flag", err_o, exp_err(fc, ic));
               rd(4'h8, d);
               check("R6 freq word", d, sat32(exp_rate(fc, ic, oc, 1'b0, 1'b0)));
            end
         end
      end

      // R6 bypass and power-down
      wr(4'h0, (32'd20 << 9) | (32'd3 << 4) | (32'd1 << 2) | 32'h2);
      check("R6 bypass rate", rate_o, REF);
      wr(4'h0, (32'd20 << 9) | (32'd3 << 4) | (32'd1 << 2) | 32'h1);
      check("R6 power-down rate", rate_o, 0);
      rd(4'h8, d); check("R6 power-down freq word", d, 0);
      wr(4'h0, (32'd20 << 9) | (32'd3 << 4) | 32'h3);
      check("R6 bypass over power-down", rate_o, REF);

      // R2 masking and low address bits
      wr(4'h1, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R2 ctrl mask", d, 32'h00F0_FFFF);
      check("R8 error on out-of-range", err_o, 1);
      check("R7 lock cleared by write", lock_o, 0);

      // R8 cleared by legal write; R7 full settle timing
      wr(4'h0, (32'd14 << 9) | (32'd0 << 4) | (32'd1 << 2));
      check("R8 error cleared", err_o, 0);
      check("R7 lock low after write", lock_o, 0);
      repeat (SETTLE - 1) @(negedge clk);
      check("R7 lock low one edge early", lock_o, 0);
      @(negedge clk);
      check("R7 lock high at settle", lock_o, 1);
      repeat (5) @(negedge clk);
      check("R7 lock stays high", lock_o, 1);

      // R11 restart during settling
      wr(4'h0, (32'd17 << 9) | (32'd1 << 2));
      repeat (4) @(negedge clk);
      wr(4'h0, (32'd23 << 9) | (32'd1 << 2));
      repeat (SETTLE - 1) @(negedge clk);
      check("R11 lock low after restart", lock_o, 0);
      @(negedge clk);
      check("R11 lock high after restart settle", lock_o, 1);

      // R9 writes to status and freq ignored
      rd(4'h0, ctl_keep);
      wr(4'h4, 32'hFFFF_FFFF);
      check("R9 status write keeps lock", lock_o, 1);
      check("R9 status write keeps error", err_o, 0);
      rd(4'h0, d); check("R9 status write keeps ctrl", d, ctl_keep);
      wr(4'h8, 32'hFFFF_FFFF);
      check("R9 freq write keeps lock", lock_o, 1);
      rd(4'h0, d); check("R9 freq write keeps ctrl", d, ctl_keep);
      rd(4'h8, d); check("R9 freq word unchanged", d, sat32(exp_rate(23, 0, 1, 1'b0, 1'b0)));

      // R10 monitor storage
      wr(4'hC, 32'hA5A5_5A5A);
      rd(4'hC, d); check("R10 monitor readback", d, 32'hA5A5_5A5A);
      check("R10 monitor keeps lock", lock_o, 1);
      rd(4'h0, d); check("R10 monitor keeps ctrl", d, ctl_keep);
      wr(4'hF, 32'h0123_4567);
      rd(4'hC, d); check("R10 monitor second value", d, 32'h0123_4567);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule